// File: doc/BRIEF.md
# PHY management interrupt logic

This block keeps the interrupt control and interrupt status words of an Ethernet PHY's management register file. Software reaches it through a simple register port: an address, write data with a write strobe, and a read strobe with combinational read data. Interrupts come from a link-status-change event or from a software test bit. While interrupts are enabled, an interrupt sets a sticky pending flag, pulls the active-low interrupt pin low and, when the management-line option is on, asks the serial management logic to send one pulse.

The pending flag has a two-step clear. Software reads the basic status register (address 1) and then the interrupt status register (address 18). A one-bit armed flag follows this order. A read of address 1 arms it. A read of any other address disarms it. A read of address 18 while armed clears the pending flag at the end of that read cycle, so the data returned by that read still shows the flag set. The driver-strength and link-criteria bits are only stored here.

Top module: `phy_irq_ctrl`

## Requirements
- R1: After reset the control word reads 0, the pending flag is 0, irq_no is 1 and mdio_pulse_o is 0.
- R2: A write to address 17 stores wdata_i[3:0]. Bit 0 is the test bit, bit 1 is the interrupt enable, bit 2 is the link-criteria select and bit 3 is the driver-strength select. A read of address 17 returns these bits in [3:0] and 0 in [15:4]. Write data in bits 15:4 has no effect.
- R3: A read of address 18 returns the pending flag in bit 15, clk_ok_i in bit 14 and 0 in bits 13:0. Writes to address 18 have no effect. A read of any address other than 17 or 18 returns 0.
- R4: When the stored enable bit is 1 in a cycle where link_evt_i is 1 or the stored test bit is 1, the pending flag is 1 from the next cycle. When the enable bit is 0, neither source sets the flag.
- R5: irq_no is 0 exactly when the pending flag and the enable bit are both 1. Otherwise it is 1.
- R6: A read of address 1, followed by a read of address 18 with no other read in between, clears the pending flag from the cycle after the address-18 read. The read data of that address-18 read still has bit 15 set. Cycles with no read may come between the two reads.
- R7: Any other read between the two reads breaks the sequence, and so does a read of 18 with no earlier read of 1. In these cases the flag is not cleared. No event other than a qualifying read clears the flag, and clearing the enable bit does not clear it either.
- R8: When a qualifying clear and a set condition (R4) fall in the same cycle, the flag stays 1.
- R9: mdio_pulse_o is 1 for exactly one cycle: the first cycle in which the pending flag is 1 after being 0. It needs line_irq_en_i and the enable bit both at 1 in that cycle, and it is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| link_evt_i | input | 1 | Link-status-change event, one cycle per event |
| clk_ok_i | input | 1 | Power-up done and clocks stable |
| line_irq_en_i | input | 1 | Management-line interrupt option on |
| irq_no | output | 1 | Interrupt pin, active low |
| mdio_pulse_o | output | 1 | Request to pulse the management data line |

## Verification
The assertions assume that we_i and re_i are never high in the same cycle. They also assume that a read strobe always comes with a valid address. The stimulus drives at most one strobe per cycle, and it picks addresses from a set weighted toward 1, 17 and 18 so that arming, breaking and clearing all happen often. link_evt_i is kept sparse and the test bit is toggled by random writes. This lets the pending flag both rise and clear many times, including cycles where a clear and a set collide.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 5;
  localparam int ADDR_BSR  = 1;
  localparam int ADDR_IEN  = 17;
  localparam int ADDR_ISR  = 18;
  localparam int EN_BITS   = 4;
  localparam int EN_TEST   = 0;
  localparam int EN_IRQ    = 1;
  localparam int EN_LNK    = 2;
  localparam int EN_DRV    = 3;
  localparam int ST_PEND   = 15;
  localparam int ST_CLKOK  = 14;
endpackage

// File: rtl/phy_irq_regs.sv
module phy_irq_regs
  import phy_irq_pkg::*;
#(
  parameter int AW      = ADDR_W,
  parameter int NB      = EN_BITS,
  parameter int ADDR_EN = ADDR_IEN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [NB-1:0] wdata_i,
  output logic [NB-1:0] en_q_o
);
  logic hit;
  assign hit = we_i && (addr_i == AW'(ADDR_EN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  en_q_o <= '0;
    else if (hit) en_q_o <= wdata_i;
  end

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(en_q_o));
endmodule

// File: rtl/phy_irq_clr_seq.sv
module phy_irq_clr_seq
  import phy_irq_pkg::*;
#(
  parameter int AW     = ADDR_W,
  parameter int ADDR_A = ADDR_BSR,
  parameter int ADDR_B = ADDR_ISR
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  output logic          clr_o
);
  logic armed_q;
  logic rd_a, rd_b;

  assign rd_a  = re_i && (addr_i == AW'(ADDR_A));
  assign rd_b  = re_i && (addr_i == AW'(ADDR_B));
  assign clr_o = rd_b && armed_q;

  // any read re-decides the armed state; idle cycles keep it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   armed_q <= 1'b0;
    else if (re_i) armed_q <= rd_a;
  end

  p_break_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !rd_a) |=> !clr_o);
  p_arm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a |=> (rd_b -> clr_o));
endmodule

// File: rtl/phy_irq_pend.sv
module phy_irq_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  input  logic line_en_i,
  output logic pend_o,
  output logic irq_no,
  output logic pulse_o
);
  logic pend_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o   <= 1'b0;
      pend_d_q <= 1'b0;
    end else begin
      pend_d_q <= pend_o;
      if (set_i)      pend_o <= 1'b1;  // set beats clear
      else if (clr_i) pend_o <= 1'b0;
    end
  end

  assign irq_no  = ~(pend_o & irq_en_i);
  assign pulse_o = pend_o & ~pend_d_q & irq_en_i & line_en_i;

  p_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_o);
  p_collide_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i) |=> pend_o);
  p_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !pend_o);
  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !clr_i) |=> pend_o);
  p_one_clk_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
  p_pulse_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> (pend_o && !irq_no));
endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
  import phy_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic          re_i,
  output logic [DW-1:0] rdata_o,
  input  logic          link_evt_i,
  input  logic          clk_ok_i,
  input  logic          line_irq_en_i,
  output logic          irq_no,
  output logic          mdio_pulse_o
);
  logic [EN_BITS-1:0] en_q;
  logic               clr, set, pend;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i[DW-1:EN_BITS];

  phy_irq_regs #(.AW(AW), .NB(EN_BITS), .ADDR_EN(ADDR_IEN)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i[EN_BITS-1:0]), .en_q_o(en_q));

  phy_irq_clr_seq #(.AW(AW), .ADDR_A(ADDR_BSR), .ADDR_B(ADDR_ISR)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .re_i(re_i), .addr_i(addr_i),
    .clr_o(clr));

  assign set = en_q[EN_IRQ] & (link_evt_i | en_q[EN_TEST]);

  phy_irq_pend u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set), .clr_i(clr),
    .irq_en_i(en_q[EN_IRQ]), .line_en_i(line_irq_en_i),
    .pend_o(pend), .irq_no(irq_no), .pulse_o(mdio_pulse_o));

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(ADDR_IEN)) begin
      rdata_o[EN_BITS-1:0] = en_q;
    end else if (addr_i == AW'(ADDR_ISR)) begin
      rdata_o[ST_PEND]  = pend;
      rdata_o[ST_CLKOK] = clk_ok_i;
    end
  end

  p_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && re_i));
  p_rsvd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(ADDR_IEN)) |-> (rdata_o[DW-1:EN_BITS] == '0));
  p_isr_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(ADDR_ISR)) |-> (rdata_o[ST_CLKOK-1:0] == '0));
  p_pin_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no) |-> en_q[EN_IRQ]);
endmodule

// File: tb/phy_irq_ctrl_test.sv
module phy_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [15:0] wdata_i = '0, rdata_o;
  logic        we_i = 0, re_i = 0, link_evt_i = 0, clk_ok_i = 0, line_irq_en_i = 0;
  logic        irq_no, mdio_pulse_o;

  int n_chk = 0, n_bad = 0;
  logic [3:0] m_en;
  logic       m_pend, m_pend_d, m_armed;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  phy_irq_ctrl uut (.*);

  function automatic logic [15:0] exp_rd(logic [4:0] a);
    if (a == 5'd17) return {12'h000, m_en};
    if (a == 5'd18) return {m_pend, clk_ok_i, 14'h0};
    return 16'h0;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check, advance model at posedge
  task automatic step(logic w, logic r, logic [4:0] a, logic [15:0] d, logic ev);
    logic s, c;
    @(negedge clk_i);
    we_i = w; re_i = r; addr_i = a; wdata_i = d; link_evt_i = ev;
    #1;
    if (r) chk((a == 5'd18) ? "R3/R6" : "R2/R3", rdata_o, exp_rd(a));
    chk("R5", {15'h0, irq_no}, {15'h0, ~(m_pend & m_en[1])});
    chk("R9", {15'h0, mdio_pulse_o},
        {15'h0, m_pend & ~m_pend_d & m_en[1] & line_irq_en_i});
    s = m_en[1] & (ev | m_en[0]);
    c = r && a == 5'd18 && m_armed;
    @(posedge clk_i);
    m_pend_d = m_pend;
    m_pend   = s ? 1'b1 : (c ? 1'b0 : m_pend);
    if (r) m_armed = (a == 5'd1);
    if (w && a == 5'd17) m_en = d[3:0];
  endtask

  task automatic idle(); step(0, 0, 5'd0, 16'h0, 0); endtask

  initial begin
    #(CLK_PERIOD * 300000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [4:0] a;
    int sel;
    void'($urandom(32'h1234_5678));
    m_en = 0; m_pend = 0; m_pend_d = 0; m_armed = 0;
    #(CLK_PERIOD * 2 + 3);
    // R1 reset state
    chk("R1", {15'h0, irq_no}, 16'h1);
    chk("R1", {15'h0, mdio_pulse_o}, 16'h0);
    rst_ni = 1'b1;
    step(0, 1, 5'd17, 0, 0);
    clk_ok_i = 1; line_irq_en_i = 1;
    step(0, 1, 5'd18, 0, 0);
    // R4 disabled: event and test bit ignored
    step(1, 0, 5'd17, 16'hFFF1, 0);
    step(0, 0, 5'd0, 0, 1);
    idle();
    step(0, 1, 5'd18, 0, 0);
    chk("R4", {15'h0, m_pend}, 16'h0);
    // R2 reserved bits, R3 write to 18 ignored
    step(1, 0, 5'd17, 16'hFFFE, 0);
    step(1, 0, 5'd18, 16'h0000, 0);
    step(0, 1, 5'd17, 0, 0);
    // R4 event sets, R9 pulse
    step(0, 0, 5'd0, 0, 1);
    idle(); idle();
    step(0, 1, 5'd18, 0, 0);
    // R7 read 18 without arming, broken sequence
    step(0, 1, 5'd18, 0, 0);
    step(0, 1, 5'd1, 0, 0);
    step(0, 1, 5'd2, 0, 0);
    step(0, 1, 5'd18, 0, 0);
    step(0, 1, 5'd18, 0, 0);
    chk("R7", {15'h0, m_pend}, 16'h1);
    // R7 disabling keeps flag; R6 clear with idle gap
    step(1, 0, 5'd17, 16'h0, 0);
    step(1, 0, 5'd17, 16'h2, 0);
    step(0, 1, 5'd1, 0, 0);
    idle();
    step(0, 1, 5'd18, 0, 0);
    step(0, 1, 5'd18, 0, 0);
    chk("R6", {15'h0, m_pend}, 16'h0);
    // R8 clear collides with event
    step(0, 0, 5'd0, 0, 1);
    step(0, 1, 5'd1, 0, 0);
    step(0, 1, 5'd18, 0, 1);
    step(0, 1, 5'd18, 0, 0);
    chk("R8", {15'h0, m_pend}, 16'h1);
    // R9 pulse suppressed when line option off
    line_irq_en_i = 0;
    step(0, 1, 5'd1, 0, 0);
    step(0, 1, 5'd18, 0, 0);
    step(0, 0, 5'd0, 0, 1);
    idle();
    line_irq_en_i = 1;
    // random mix
    for (int i = 0; i < 4000; i++) begin
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1, 2: a = 5'd1;
        3, 4:    a = 5'd17;
        5, 6, 7: a = 5'd18;
        default: a = 5'($urandom_range(0, 31));
      endcase
      if ($urandom_range(0, 49) == 0) line_irq_en_i = ~line_irq_en_i;
      if ($urandom_range(0, 99) == 0) clk_ok_i = ~clk_ok_i;
      sel = $urandom_range(0, 7);
      step(sel == 0 && ($urandom_range(0, 3) != 0), sel >= 2 && sel <= 5, a,
           16'($urandom) & 16'hFFFE | 16'($urandom_range(0, 7) == 0),
           $urandom_range(0, 19) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule